// File: doc/BRIEF.md
# Three-Voice Pulse and Sawtooth Tone Generator

The block is a small tone generator that hangs off a cartridge-style CPU write bus. It has three voices. Two are pulse voices, each with a 16-step duty sequencer, a 4-bit volume and a flag that holds the output at full volume. The third is a sawtooth voice. Its ramp comes from an 8-bit accumulator: a 6-bit rate is added to it on alternate steps of a repeating step cycle.

Every voice owns a 12-bit period timer, and that timer runs once per clock, where one clock is one CPU cycle. Software programs the voices by writing nine byte-wide registers. The block presents each voice's raw integer level, plus the unsigned integer sum of all three, to whatever stage does the analog or scaled mixing downstream.

The write bus is a plain register-write strobe and is never back-pressured: every strobed write is taken in the cycle it is presented. The level outputs are plain status-like values that are always valid, so there is no valid/ready pair at either edge of the block.

Top module: `tri_voice_gen`

## Requirements
- R1: The registers of pulse voice A sit at addresses 0x9000, 0x9001 and 0x9002. Pulse voice B uses 0xA000 to 0xA002, and the sawtooth uses 0xB000 to 0xB002. A write to any other address, such as 0x9003, 0x9100 or 0xC000, changes nothing.
- R2: A pulse voice's control register (base+0) is laid out as follows: bit 7 is the constant-level flag, bits 6:4 are the duty value (0 to 7), and bits 3:0 are the volume.
- R3: In every voice, base+1 writes period bits 7:0. Base+2 writes period bits 11:8 from its data bits 3:0 and sets the voice enable from its data bit 7.
- R4: The sawtooth control register (base+0) takes the 6-bit rate from bits 5:0. Bits 7:6 are ignored.
- R5: On each clock, an enabled voice checks its timer. If the timer is zero, it reloads from the period (a period of 0 acts as 1) and the voice's step advances. Otherwise the timer drops by one. A step therefore lasts period+1 clocks, with a minimum of 2.
- R6: The pulse step counts 0 to 15 and then wraps. The pulse level equals the volume when the constant-level flag is set or when step ≤ duty; otherwise it is 0.
- R7: Each sawtooth reload advances its step by one. When the step reaches 1, 3 or 5, the rate is added to the 8-bit accumulator. When the step reaches 6, the step and the accumulator both clear to 0.
- R8: The sawtooth level is the accumulator shifted right by 3, which gives a 5-bit value.
- R9: A disabled voice keeps its timer and step frozen and drives a level of 0. When it is enabled again, it resumes from the frozen state.
- R10: A synchronous active-high reset clears all registers, timers, steps and the accumulator. While reset is asserted and afterwards, every output reads 0.
- R11: The 6-bit sum output equals pulse A + pulse B + sawtooth. It never exceeds 53.
- R12: A register write is captured at the clock edge where the strobe is high. The levels are derived from the stored state alone, so they change right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| pulse_a_lvl | output | 4 | Pulse voice A level |
| pulse_b_lvl | output | 4 | Pulse voice B level |
| saw_lvl | output | 5 | Sawtooth level |
| mix_sum | output | 6 | Unsigned sum of the three levels |

## Verification
A write that changes a level, such as the volume, the duty or the enable, is visible right after the edge that captures it. The timer's first reload happens on the edge after the enable. After that, the step moves every period+1 edges, so the bench works out the index of the edge where each transition is due (for example edge 30 after re-enabling a frozen voice, and edge 3886 for period 0x102). The sawtooth values are fixed for each edge index after enable. The bench drives on the falling edge and samples on the falling edge after each rising edge. The duty checks count the high samples over exactly one 32-clock period, so the result does not depend on phase.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int PER_W      = 12;
  localparam int VOL_W      = 4;
  localparam int DUTY_W     = 3;
  localparam int STEP_W     = 4;
  localparam int RATE_W     = 6;
  localparam int ACC_W      = 8;
  localparam int SAW_SHIFT  = 3;
  localparam int SAW_STEP_W = 3;
  localparam int SAW_WRAP   = 6;
  localparam int NUM_REGS   = 3;
  localparam int FLAG_BIT   = 7;
  localparam int DUTY_LSB   = 4;

  localparam logic [ADDR_W-1:0] PULSE_A_BASE = 16'h9000;
  localparam logic [ADDR_W-1:0] PULSE_B_BASE = 16'hA000;
  localparam logic [ADDR_W-1:0] SAW_BASE     = 16'hB000;

  typedef enum logic [1:0] {
    REG_CTL = 2'd0,
    REG_PLO = 2'd1,
    REG_PHI = 2'd2
  } reg_idx_e;
endpackage

// File: rtl/snd_reg_decode.sv
module snd_reg_decode #(
  parameter int ADDR_W = 16,
  parameter int NV     = 3,
  parameter int NR     = 3,
  parameter logic [NV*ADDR_W-1:0] BASES = '0
) (
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  output logic [NV-1:0][NR-1:0]    wr_sel
);
  for (genvar v = 0; v < NV; v++) begin : g_voice
    for (genvar r = 0; r < NR; r++) begin : g_reg
      assign wr_sel[v][r] = wr_en &&
        (wr_addr == BASES[v*ADDR_W +: ADDR_W] + ADDR_W'(r));
    end
  end
endmodule

// File: rtl/snd_period_timer.sv
module snd_period_timer #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= (period == '0) ? PER_W'(1) : period;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9: an idle timer holds its count
  p_timer_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q));
  // R5: a reload never leaves the timer at zero
  p_reload_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt_q != '0);
  // R5: a running timer that is not at zero counts down by one
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    run && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/snd_pulse_voice.sv
module snd_pulse_voice #(
  parameter int DATA_W   = 8,
  parameter int PER_W    = 12,
  parameter int VOL_W    = 4,
  parameter int DUTY_W   = 3,
  parameter int STEP_W   = 4,
  parameter int FLAG_BIT = 7,
  parameter int DUTY_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_plo,
  input  logic              wr_phi,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VOL_W-1:0]  level
);
  localparam int HI_W = PER_W - DATA_W;

  logic              flag_q, en_q, tick;
  logic [DUTY_W-1:0] duty_q;
  logic [VOL_W-1:0]  vol_q;
  logic [PER_W-1:0]  per_q;
  logic [STEP_W-1:0] step_q;
  logic              unused_hi_bits;

  assign unused_hi_bits = &{1'b0, wr_data[FLAG_BIT-1:HI_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      duty_q <= '0;
      vol_q  <= '0;
      per_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        flag_q <= wr_data[FLAG_BIT];
        duty_q <= wr_data[DUTY_LSB +: DUTY_W];
        vol_q  <= wr_data[VOL_W-1:0];
      end
      if (wr_plo) per_q[DATA_W-1:0] <= wr_data;
      if (wr_phi) begin
        per_q[PER_W-1:DATA_W] <= wr_data[HI_W-1:0];
        en_q <= wr_data[FLAG_BIT];
      end
    end
  end

  snd_period_timer #(.PER_W(PER_W)) i_timer (
    .clk(clk), .rst(rst), .run(en_q), .period(per_q), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst)       step_q <= '0;
    else if (tick) step_q <= step_q + 1'b1;
  end

  assign level = (en_q && (flag_q || step_q <= STEP_W'(duty_q))) ? vol_q : '0;

  // R6: each reload moves the duty step on by one, wrapping at 16
  p_step_advance_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> step_q == $past(step_q) + 1'b1);
  // R9: a disabled pulse voice keeps its step
  p_step_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(step_q));
endmodule

// File: rtl/snd_saw_voice.sv
module snd_saw_voice #(
  parameter int DATA_W     = 8,
  parameter int PER_W      = 12,
  parameter int RATE_W     = 6,
  parameter int ACC_W      = 8,
  parameter int SHIFT      = 3,
  parameter int STEP_W     = 3,
  parameter int WRAP       = 6,
  parameter int FLAG_BIT   = 7,
  localparam int OUT_W     = ACC_W - SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_plo,
  input  logic              wr_phi,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OUT_W-1:0]  level
);
  localparam int HI_W = PER_W - DATA_W;

  logic              en_q, tick;
  logic [RATE_W-1:0] rate_q;
  logic [PER_W-1:0]  per_q;
  logic [STEP_W-1:0] step_q, step_nx;
  logic [ACC_W-1:0]  acc_q;
  logic              unused_bits;

  assign unused_bits = &{1'b0, wr_data[DATA_W-1:RATE_W], wr_data[FLAG_BIT-1:HI_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      per_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctl) rate_q <= wr_data[RATE_W-1:0];
      if (wr_plo) per_q[DATA_W-1:0] <= wr_data;
      if (wr_phi) begin
        per_q[PER_W-1:DATA_W] <= wr_data[HI_W-1:0];
        en_q <= wr_data[FLAG_BIT];
      end
    end
  end

  snd_period_timer #(.PER_W(PER_W)) i_timer (
    .clk(clk), .rst(rst), .run(en_q), .period(per_q), .tick(tick)
  );

  assign step_nx = step_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      acc_q  <= '0;
    end else if (tick) begin
      if (step_nx == STEP_W'(WRAP)) begin
        step_q <= '0;
        acc_q  <= '0;
      end else begin
        step_q <= step_nx;
        if (step_nx[0]) acc_q <= acc_q + ACC_W'(rate_q);
      end
    end
  end

  assign level = en_q ? acc_q[ACC_W-1:SHIFT] : '0;

  // R7: the wrap step is never held as state
  p_step_range_r7: assert property (@(posedge clk) disable iff (rst)
    step_q < STEP_W'(WRAP));
  // R7: completing the cycle clears both step and accumulator
  p_cycle_clear_r7: assert property (@(posedge clk) disable iff (rst)
    tick && step_nx == STEP_W'(WRAP) |=> acc_q == '0 && step_q == '0);
  // R9: a disabled sawtooth keeps step and accumulator
  p_saw_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(step_q) && $stable(acc_q));
endmodule

// File: rtl/tri_voice_gen.sv
module tri_voice_gen
  import snd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PER_W,
  parameter int VW = VOL_W,
  localparam int SAW_W = ACC_W - SAW_SHIFT,
  localparam int SUM_W = 6,
  localparam int NP    = 2,
  localparam int NV    = NP + 1,
  localparam int MAX_SUM = NP * (2**VW - 1) + ((3 * (2**RATE_W - 1)) >> SAW_SHIFT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [VW-1:0]    pulse_a_lvl,
  output logic [VW-1:0]    pulse_b_lvl,
  output logic [SAW_W-1:0] saw_lvl,
  output logic [SUM_W-1:0] mix_sum
);
  logic [NV-1:0][NUM_REGS-1:0] wr_sel;
  logic [NP-1:0][VW-1:0]       plvl;

  snd_reg_decode #(
    .ADDR_W(AW), .NV(NV), .NR(NUM_REGS),
    .BASES({SAW_BASE, PULSE_B_BASE, PULSE_A_BASE})
  ) i_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pulse
    snd_pulse_voice #(
      .DATA_W(DW), .PER_W(PW), .VOL_W(VW), .DUTY_W(DUTY_W),
      .STEP_W(STEP_W), .FLAG_BIT(FLAG_BIT), .DUTY_LSB(DUTY_LSB)
    ) i_pulse (
      .clk(clk), .rst(rst),
      .wr_ctl(wr_sel[p][REG_CTL]), .wr_plo(wr_sel[p][REG_PLO]),
      .wr_phi(wr_sel[p][REG_PHI]), .wr_data(wr_data),
      .level(plvl[p])
    );
  end

  snd_saw_voice #(
    .DATA_W(DW), .PER_W(PW), .RATE_W(RATE_W), .ACC_W(ACC_W),
    .SHIFT(SAW_SHIFT), .STEP_W(SAW_STEP_W), .WRAP(SAW_WRAP), .FLAG_BIT(FLAG_BIT)
  ) i_saw (
    .clk(clk), .rst(rst),
    .wr_ctl(wr_sel[NP][REG_CTL]), .wr_plo(wr_sel[NP][REG_PLO]),
    .wr_phi(wr_sel[NP][REG_PHI]), .wr_data(wr_data),
    .level(saw_lvl)
  );

  assign pulse_a_lvl = plvl[0];
  assign pulse_b_lvl = plvl[1];
  assign mix_sum = SUM_W'(plvl[0]) + SUM_W'(plvl[1]) + SUM_W'(saw_lvl);

  // R1: a write reaches at most one register
  p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
  // R11: the sum stays inside its documented range
  p_sum_max_r11: assert property (@(posedge clk) disable iff (rst)
    mix_sum <= SUM_W'(MAX_SUM));
  // R10: the cycle after a reset edge is silent
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> mix_sum == '0 && saw_lvl == '0);
endmodule

// File: tb/test_tri_voice_gen.sv
module test_tri_voice_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  pulse_a_lvl, pulse_b_lvl;
  logic [4:0]  saw_lvl;
  logic [5:0]  mix_sum;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  tri_voice_gen i_tri_voice_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_a_lvl(pulse_a_lvl), .pulse_b_lvl(pulse_b_lvl),
    .saw_lvl(saw_lvl), .mix_sum(mix_sum)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 reset pulse A", pulse_a_lvl, 0);
    check("R10 reset sum", mix_sum, 0);
    wr(16'h9000, 8'h8F); wr(16'h9002, 8'h80);
    check("R2 flag volume 15", pulse_a_lvl, 15);
    do_reset();
    check("R10 reset clears level", pulse_a_lvl, 0);
    wr(16'h9002, 8'h80);
    check("R10 volume cleared by reset", pulse_a_lvl, 0);
  endtask

  task automatic t_decode();
    do_reset();
    wr(16'h9000, 8'h86); wr(16'h9002, 8'h80);
    check("R12 level right after write", pulse_a_lvl, 6);
    wr(16'h9003, 8'h00);
    check("R1 0x9003 ignored", pulse_a_lvl, 6);
    wr(16'h9100, 8'h00);
    check("R1 0x9100 ignored", pulse_a_lvl, 6);
    wr(16'hC000, 8'h00);
    check("R1 0xC000 ignored", pulse_a_lvl, 6);
    check("R1 pulse B untouched", pulse_b_lvl, 0);
  endtask

  task automatic t_duty();
    int hi;
    do_reset();
    wr(16'hA000, 8'h39); wr(16'hA001, 8'h00); wr(16'hA002, 8'h80);
    check("R6 step 0 within duty", pulse_b_lvl, 9);
    repeat (3) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 32; i++) begin
      if (pulse_b_lvl == 4'd9) hi++;
      else if (pulse_b_lvl != 4'd0) check("R6 level value", pulse_b_lvl, 0);
      @(negedge clk);
    end
    check("R6 duty 3 high count", hi, 8);
    check("R1 pulse A silent", pulse_a_lvl, 0);
    wr(16'hA000, 8'h79);
    repeat (2) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 32; i++) begin
      if (pulse_b_lvl == 4'd9) hi++;
      @(negedge clk);
    end
    check("R2 duty 7 high count", hi, 16);
    wr(16'hA000, 8'h8C);
    hi = 0;
    for (int i = 0; i < 32; i++) begin
      if (pulse_b_lvl == 4'd12) hi++;
      @(negedge clk);
    end
    check("R2 constant flag", hi, 32);
    check("R11 sum equals lone voice", mix_sum, pulse_b_lvl);
  endtask

  task automatic t_freeze();
    int first;
    do_reset();
    wr(16'h9000, 8'h05); wr(16'h9001, 8'h00); wr(16'h9002, 8'h80);
    check("R6 step 0 at enable", pulse_a_lvl, 5);
    wr(16'h9002, 8'h00);
    check("R9 disabled level", pulse_a_lvl, 0);
    repeat (50) @(negedge clk);
    check("R9 still silent", pulse_a_lvl, 0);
    wr(16'h9002, 8'h80);
    check("R9 resumes at step 1", pulse_a_lvl, 0);
    first = -1;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      if (first < 0 && pulse_a_lvl != 4'd0) first = i;
    end
    check("R9 frozen state resumed", first, 30);
  endtask

  task automatic t_period();
    int first;
    do_reset();
    wr(16'h9000, 8'h07); wr(16'h9001, 8'h02); wr(16'h9002, 8'h81);
    check("R3 level at enable", pulse_a_lvl, 7);
    first = -1;
    for (int i = 1; i < 5000; i++) begin
      @(negedge clk);
      if (first < 0 && pulse_a_lvl != 4'd0) first = i;
    end
    check("R5 period 0x102 step wrap edge", first, 3886);
  endtask

  task automatic t_saw();
    int exp_v;
    do_reset();
    wr(16'hB000, 8'hE0); wr(16'hB001, 8'h00); wr(16'hB002, 8'h80);
    check("R7 saw start", saw_lvl, 0);
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      if (i <= 4)       exp_v = 4;
      else if (i <= 8)  exp_v = 8;
      else if (i <= 10) exp_v = 12;
      else if (i <= 12) exp_v = 0;
      else              exp_v = 4;
      check($sformatf("R7 R8 R4 saw edge %0d", i), saw_lvl, exp_v);
    end
    wr(16'hB002, 8'h00);
    check("R9 saw disabled", saw_lvl, 0);
  endtask

  task automatic t_sum();
    do_reset();
    wr(16'h9000, 8'h8F); wr(16'h9002, 8'h80);
    wr(16'hA000, 8'h8F); wr(16'hA002, 8'h80);
    wr(16'hB000, 8'h3F); wr(16'hB001, 8'h00); wr(16'hB002, 8'h80);
    check("R11 sum at enable", mix_sum, 30);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      if (i == 1) check("R11 sum edge 1", mix_sum, 37);
      if (i == 5) check("R11 sum edge 5", mix_sum, 45);
      if (i == 9) begin
        check("R8 saw max", saw_lvl, 23);
        check("R11 sum max", mix_sum, 53);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_duty();
    t_freeze();
    t_period();
    t_saw();
    t_sum();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule